// File: doc/BRIEF.md
# Reset-Vector Fetch and No-Operation Sequencer

This block models the bus cycles of a very small 8-bit processor front end that has a 16-bit address output and an 8-bit read-data input. When reset is released it reads a two-byte start vector from the top of the address space. The byte at the second-highest location (0xFFFE) is the high half and the byte at the highest location (0xFFFF) is the low half. The resulting value goes into the program counter. From then on the block fetches one opcode per instruction cycle and advances the counter after every fetch.

The only opcode it decodes is 0x12, the no-operation code. Any other byte raises a sticky illegal-opcode flag and is then handled as a one-byte no-op, so the fetch stream never stops. The read interface has no back-pressure. Memory must return the addressed byte in the same cycle that the read strobe is high, and the block captures it at the end of that cycle. An active-low halt input freezes the sequencer for as long as it is held low.

A fetch cycle is one clock with the strobe high. It is followed by `EXEC_CYCLES` clocks of execution with the strobe low.

Top module: `reset_vec_nop_seq`

## Requirements
- R1: While `rst_n` is low, `rd_stb` and `illegal_op` are 0. After release, the first strobe appears in the cycle that follows the first rising edge at which `rst_n` is seen high.
- R2: The first two strobes after reset come in consecutive cycles, with `addr` = 0xFFFE and then 0xFFFF.
- R3: The byte read at 0xFFFE forms bits 15:8 of the start address and the byte read at 0xFFFF forms bits 7:0. The first opcode fetch uses that address and comes in the cycle directly after the 0xFFFF read.
- R4: Each opcode fetch holds `rd_stb` high for exactly one clock. It is followed by `EXEC_CYCLES` clocks with `rd_stb` low. The next fetch is at the previous fetch address plus one.
- R5: The program counter wraps from 0xFFFF to 0x0000.
- R6: A fetched opcode of 0x12 leaves `illegal_op` unchanged. Any other opcode value sets `illegal_op` from the following cycle, and fetching continues at the next address.
- R7: Once set, `illegal_op` stays at 1 until reset.
- R8: While `halt_n` is low, `rd_stb` is 0 and `addr` holds its value. After `halt_n` returns high, the fetch sequence resumes with no address skipped or repeated.
- R9: Asserting reset during normal fetching restarts the sequence at the 0xFFFE vector read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_n | input | 1 | Pause request, active low |
| rd_data | input | 8 | Byte returned by memory for the current `addr` |
| addr | output | 16 | Address of the current bus cycle |
| rd_stb | output | 1 | High for one clock in each read cycle |
| illegal_op | output | 1 | Sticky flag set by a fetched opcode other than 0x12 |

## Verification
The bench builds the block with `EXEC_CYCLES` = 2 instead of the default 1. This makes each instruction cycle three clocks long, so the spacing check on fetch strobes can tell a correct execute count apart from one that is off by one in either direction. Three memory images are used:
- a constant 0x12 image, which gives a 0x1212 start address;
- a vector pointing at 0xFFFD, which drives the counter through the wrap and fetches a non-0x12 byte;
- a vector pointing at 0x4000 with a single illegal opcode in the middle of a no-op run.

Halts injected mid-stream and a reset during fetching exercise freezing of the sequence and restart from the vector.

// File: rtl/nopseq_pkg.sv
package nopseq_pkg;
  typedef enum logic [2:0] {
    ST_PRE   = 3'd0,
    ST_VHI   = 3'd1,
    ST_VLO   = 3'd2,
    ST_FETCH = 3'd3,
    ST_EXEC  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/nopseq_ctrl.sv
module nopseq_ctrl
  import nopseq_pkg::*;
#(
  parameter int EXEC_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_n,
  output seq_state_t state
);
  localparam int CW = $clog2(EXEC_CYCLES + 1) + 1;
  localparam logic [CW-1:0] LAST = CW'(EXEC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_PRE;
      cnt_q <= '0;
    end else if (halt_n) begin
      case (state)
        ST_PRE:   state <= ST_VHI;
        ST_VHI:   state <= ST_VLO;
        ST_VLO:   state <= ST_FETCH;
        ST_FETCH: begin
          state <= ST_EXEC;
          cnt_q <= '0;
        end
        ST_EXEC: begin
          if (cnt_q == LAST) begin
            state <= ST_FETCH;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default:  state <= ST_PRE;
      endcase
    end
  end

  // R2: the low vector byte is read right after the high byte
  p_vec_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VHI && halt_n) |=> (state == ST_VLO));

  // R3: the first opcode fetch follows the low vector read
  p_first_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VLO && halt_n) |=> (state == ST_FETCH));
endmodule

// File: rtl/nopseq_pc.sv
module nopseq_pc
  import nopseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_n,
  input  seq_state_t          state,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [2*DATA_W-1:0] pc
);
  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      pc   <= '0;
    end else if (halt_n) begin
      case (state)
        ST_VHI:   hi_q <= rd_data;
        ST_VLO:   pc   <= {hi_q, rd_data};
        ST_FETCH: pc   <= pc + 1'b1;
        default:  ;
      endcase
    end
  end

  // R5: the increment wraps the counter to zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && halt_n && pc == '1) |=> (pc == '0));
endmodule

// File: rtl/nopseq_decode.sv
module nopseq_decode
  import nopseq_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter logic [7:0]  NOP_OP = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_n,
  input  seq_state_t        state,
  input  logic [DATA_W-1:0] rd_data,
  output logic              illegal_op
);
  localparam logic [DATA_W-1:0] NOP_CODE = DATA_W'(NOP_OP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal_op <= 1'b0;
    end else if (halt_n && state == ST_FETCH && rd_data != NOP_CODE) begin
      illegal_op <= 1'b1;
    end
  end

  // R7: the flag never clears without reset
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> illegal_op);

  // R6: the no-operation code never raises the flag
  p_nop_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && rd_data == NOP_CODE && !illegal_op) |=> !illegal_op);
endmodule

// File: rtl/reset_vec_nop_seq.sv
module reset_vec_nop_seq
  import nopseq_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         EXEC_CYCLES = 1,
  parameter logic [7:0] NOP_OP      = 8'h12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_n,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [2*DATA_W-1:0] addr,
  output logic                rd_stb,
  output logic                illegal_op
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] VEC_LO_ADDR = '1;
  localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_LO_ADDR - 1'b1;

  seq_state_t        state;
  logic [ADDR_W-1:0] pc;
  logic              is_fetch;

  nopseq_ctrl #(.EXEC_CYCLES(EXEC_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .state(state)
  );

  nopseq_pc #(.DATA_W(DATA_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .state(state),
    .rd_data(rd_data), .pc(pc)
  );

  nopseq_decode #(.DATA_W(DATA_W), .NOP_OP(NOP_OP)) u_dec (
    .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .state(state),
    .rd_data(rd_data), .illegal_op(illegal_op)
  );

  always_comb begin
    case (state)
      ST_PRE, ST_VHI: addr = VEC_HI_ADDR;
      ST_VLO:         addr = VEC_LO_ADDR;
      default:        addr = pc;
    endcase
  end

  assign is_fetch = (state == ST_FETCH);
  assign rd_stb   = halt_n && (state == ST_VHI || state == ST_VLO || is_fetch);

  // R1: no read cycles while reset is held
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!rd_stb && !illegal_op));

  // R4: an opcode fetch strobe lasts one clock and the address then advances
  p_fetch_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fetch && rd_stb) |=> !rd_stb);

  p_fetch_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fetch && rd_stb) |=> (addr == $past(addr) + 1'b1));

  // R8: halt suppresses the strobe and freezes the address
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |-> !rd_stb);

  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |=> $stable(addr));
endmodule

// File: tb/reset_vec_nop_seq_test.sv
module reset_vec_nop_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int EXEC = 2;

  typedef struct {
    logic [15:0] a;
    bit          op;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_n = 1'b1;
  logic [7:0]  rd_data;
  logic [15:0] addr;
  logic        rd_stb;
  logic        illegal_op;

  int   mode = 0;
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;
  exp_t q[$];
  bit   ill_model = 1'b0;
  bit   last_op = 1'b0;
  bit   halt_seen = 1'b0;
  int   gap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a, input int m);
    logic [7:0] v;
    v = 8'h12;
    if (m == 1) begin
      if (a == 16'hFFFE) v = 8'hFF;
      if (a == 16'hFFFF) v = 8'hFD;
    end else if (m == 2) begin
      if (a == 16'hFFFE) v = 8'h40;
      if (a == 16'hFFFF) v = 8'h00;
      if (a == 16'h4002) v = 8'h3A;
    end
    return v;
  endfunction

  assign rd_data = mem_byte(addr, mode);

  reset_vec_nop_seq #(.DATA_W(8), .EXEC_CYCLES(EXEC), .NOP_OP(8'h12)) uut (
    .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .rd_data(rd_data),
    .addr(addr), .rd_stb(rd_stb), .illegal_op(illegal_op)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input bit op, input string req);
    exp_t e;
    e.a = a; e.op = op; e.req = req;
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cycles++;
    gap++;
    if (!rst_n) begin
      check(!rd_stb && !illegal_op, "R1", {rd_stb, illegal_op}, 0);
      ill_model = 1'b0;
      last_op = 1'b0;
      halt_seen = 1'b0;
    end else begin
      if (!halt_n) begin
        check(!rd_stb, "R8", rd_stb, 0);
        halt_seen = 1'b1;
      end
      if (rd_stb && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(addr == e.a, e.req, addr, e.a);
        if (e.op) begin
          check(illegal_op == ill_model, "R6", illegal_op, ill_model);
          if (last_op && !halt_seen)
            check(gap == EXEC + 1, "R4", gap, EXEC + 1);
          if (rd_data != 8'h12) ill_model = 1'b1;
        end
        last_op = e.op;
        halt_seen = 1'b0;
        gap = 0;
      end
    end
  end

  task automatic do_reset(input int m);
    @(posedge clk); #1;
    rst_n = 1'b0;
    mode = m;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!rd_stb, "R1", rd_stb, 0);
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    // test 1: constant no-op memory, with a halt mid stream
    do_reset(0);
    push(16'hFFFE, 0, "R2");
    push(16'hFFFF, 0, "R2");
    push(16'h1212, 1, "R3");
    for (int i = 1; i < 8; i++) push(16'h1212 + 16'(i), 1, "R4");
    while (q.size() > 4) @(posedge clk);
    #1 halt_n = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(!rd_stb, "R8", rd_stb, 0);
    @(posedge clk); #1 halt_n = 1'b1;
    drain();
    check(illegal_op == 1'b0, "R6", illegal_op, 0);

    // test 2: reset while running; vector 0xFFFD wraps the counter
    do_reset(1);
    push(16'hFFFE, 0, "R9");
    push(16'hFFFF, 0, "R2");
    push(16'hFFFD, 1, "R3");
    push(16'hFFFE, 1, "R4");
    push(16'hFFFF, 1, "R4");
    push(16'h0000, 1, "R5");
    push(16'h0001, 1, "R5");
    drain();
    check(illegal_op == 1'b1, "R7", illegal_op, 1);

    // test 3: one illegal opcode inside a no-op run, then cleared by reset
    do_reset(2);
    push(16'hFFFE, 0, "R2");
    push(16'hFFFF, 0, "R2");
    push(16'h4000, 1, "R3");
    for (int i = 1; i < 6; i++) push(16'h4000 + 16'(i), 1, "R6");
    while (q.size() > 2) @(posedge clk);
    #1 halt_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 halt_n = 1'b1;
    drain();
    check(illegal_op == 1'b1, "R7", illegal_op, 1);
    do_reset(0);
    check(illegal_op == 1'b0, "R1", illegal_op, 0);
    push(16'hFFFE, 0, "R9");
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule